// File: doc/BRIEF.md
# Interrupt Cause and Mask Register Pair

This block keeps two 16-bit registers: a cause register that records pending interrupt events, and a mask register that selects which events matter to the host. Event sources set cause bits through a per-bit set vector. The host can read and write both registers over a simple register bus. The bus accepts 8-bit or 16-bit writes.

The block drives a one-cycle interrupt pulse toward the host. It is not a level-sensitive AND of cause and mask. A pulse is issued in two cases. The first is when a set input hits a bit that the mask enables. The second is when the host writes a new mask value that differs from the current one while any pending cause bit lies under the old mask or the new one. A host that unmasks a pending event therefore gets a fresh pulse. So does a host that masks one off.

The host reads the registers combinationally, and every read returns the full register. Writes take effect at the clock edge. A narrow write never merges into one lane of a register: it zero-extends the byte and replaces the whole register.

Top module: `intr_cause_mask`

## Requirements
- R1: After reset the cause register, the mask register and the interrupt output are all zero.
- R2: Reading word address 0 returns the cause register and word address 1 returns the mask register, all 16 bits, whatever the width flag (1 = 16-bit, 0 = 8-bit). Every other address reads as zero.
- R3: A host write to address 0 overwrites the cause register. An 8-bit write loads bits 7:0 from the write data and clears bits 15:8.
- R4: Each bit of the set vector that is high sets the matching cause bit at the next edge. When a set bit and a host cause write land in the same cycle, the set bit wins.
- R5: A 16-bit host write to address 1 loads the full mask.
- R6: An 8-bit host write to address 1 replaces the whole mask with the zero-extended low byte of the write data, so any earlier upper bits are cleared.
- R7: A mask write raises the interrupt output for exactly the one cycle after the write edge when two conditions hold: the written value differs from the current mask, and the cause register shares a bit with the OR of the old mask and the written value. This also holds when the write clears the only enabled pending bit.
- R8: A mask write of the value already held gives no interrupt pulse, even when a pending cause bit is enabled.
- R9: A mask write that changes the mask gives no pulse when no cause bit lies under the old or the new mask.
- R10: A set-vector bit that is enabled in the current mask gives a one-cycle interrupt pulse after the edge that records it. A set bit that is not enabled gives no pulse. A host cause write never gives a pulse.
- R11: Writes to addresses other than 0 and 1 change neither register and give no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_addr_i | input | 3 | Register word address |
| host_wr_i | input | 1 | Write strobe, one cycle per write |
| host_wide_i | input | 1 | Write width: 1 = 16-bit, 0 = 8-bit (zero-extended) |
| host_wdata_i | input | 16 | Write data |
| host_rdata_o | output | 16 | Read data for the addressed register, combinational |
| cause_set_i | input | 16 | Per-bit cause set requests |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
A corrupted cause or mask bit shows up at the read port in the same cycle, because reads are combinational. It also changes whether the next mask write pulses, so a wrong register value surfaces one edge after the write that exposes it. A wrong trigger shows up on `irq_o` in the cycle right after the triggering edge, either as a missing pulse or as a pulse where none belongs. A pulse that lasts too long shows up in the cycle after that.

// File: rtl/intr_cause_mask_pkg.sv
package intr_cause_mask_pkg;

    localparam int unsigned REG_W  = 16;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned ADDR_W = 3;

    typedef logic [REG_W-1:0]  reg_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_CAUSE = 2'd1,
        SEL_MASK  = 2'd2
    } reg_sel_e;

endpackage

// File: rtl/icm_decode.sv
module icm_decode
    import intr_cause_mask_pkg::*;
#(
    parameter addr_t CAUSE_ADDR = addr_t'(0),
    parameter addr_t MASK_ADDR  = addr_t'(1)
) (
    input  addr_t    addr_i,
    input  logic     wr_i,
    input  logic     wide_i,
    input  reg_t     wdata_i,
    output reg_sel_e sel_o,
    output logic     cause_wr_o,
    output logic     mask_wr_o,
    output reg_t     wval_o
);
    localparam int unsigned HI_W = REG_W - BYTE_W;

    always_comb begin
        if (addr_i == CAUSE_ADDR)     sel_o = SEL_CAUSE;
        else if (addr_i == MASK_ADDR) sel_o = SEL_MASK;
        else                          sel_o = SEL_NONE;
    end

    assign cause_wr_o = wr_i && (sel_o == SEL_CAUSE);
    assign mask_wr_o  = wr_i && (sel_o == SEL_MASK);

    generate
        if (HI_W > 0) begin : g_narrow
            assign wval_o = wide_i ? wdata_i : {{HI_W{1'b0}}, wdata_i[BYTE_W-1:0]};
        end else begin : g_bytewide
            logic unused_wide;
            assign unused_wide = wide_i;
            assign wval_o = wdata_i;
        end
    endgenerate
endmodule

// File: rtl/icm_cause_reg.sv
module icm_cause_reg
    import intr_cause_mask_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic wr_i,
    input  reg_t wval_i,
    input  reg_t set_i,
    output reg_t cause_o
);
    typedef struct packed {
        reg_t cause;
    } cause_st_t;

    cause_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) st_d.cause = wval_i;
        st_d.cause = st_d.cause | set_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cause_o = st_q.cause;

    // R4: requested bits are present after the edge
    p_set_lands_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((cause_o & $past(set_i)) == $past(set_i)));

    // R3: without a write or set the cause holds
    p_cause_holds_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wr_i && set_i == '0) |=> $stable(cause_o));
endmodule

// File: rtl/icm_mask_reg.sv
module icm_mask_reg
    import intr_cause_mask_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic wr_i,
    input  reg_t wval_i,
    input  reg_t cause_i,
    output reg_t mask_o,
    output logic trig_o
);
    typedef struct packed {
        reg_t mask;
    } mask_st_t;

    mask_st_t st_d, st_q;
    logic     changed;
    logic     overlap;

    always_comb begin
        st_d    = st_q;
        changed = (wval_i != st_q.mask);
        overlap = |((st_q.mask | wval_i) & cause_i);
        trig_o  = wr_i && changed && overlap;
        if (wr_i) st_d.mask = wval_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign mask_o = st_q.mask;

    // R5: the mask only moves on a mask write
    p_mask_holds_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_i |=> $stable(mask_o));

    // R6: a write replaces the entire register
    p_mask_loads_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i |=> (mask_o == $past(wval_i)));
endmodule

// File: rtl/icm_irq_gen.sv
module icm_irq_gen
    import intr_cause_mask_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic mask_trig_i,
    input  reg_t set_i,
    input  reg_t mask_i,
    output logic irq_o
);
    typedef struct packed {
        logic irq;
    } irq_st_t;

    irq_st_t st_d, st_q;
    logic    set_hit;

    always_comb begin
        set_hit    = |(set_i & mask_i);
        st_d.irq   = mask_trig_i || set_hit;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign irq_o = st_q.irq;

    // R7: a qualifying mask write pulses next cycle
    p_mask_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mask_trig_i |=> irq_o);

    // R10: an enabled set request pulses next cycle
    p_set_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set_i & mask_i) != '0 |=> irq_o);

    // R8: no trigger, no pulse
    p_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!mask_trig_i && (set_i & mask_i) == '0) |=> !irq_o);
endmodule

// File: rtl/intr_cause_mask.sv
module intr_cause_mask
    import intr_cause_mask_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic [2:0]  host_addr_i,
    input  logic        host_wr_i,
    input  logic        host_wide_i,
    input  logic [15:0] host_wdata_i,
    output logic [15:0] host_rdata_o,
    input  logic [15:0] cause_set_i,
    output logic        irq_o
);
    reg_sel_e sel;
    logic     cause_wr, mask_wr, mask_trig;
    reg_t     wval, cause_q, mask_q;

    icm_decode u_decode (
        .addr_i     (host_addr_i),
        .wr_i       (host_wr_i),
        .wide_i     (host_wide_i),
        .wdata_i    (host_wdata_i),
        .sel_o      (sel),
        .cause_wr_o (cause_wr),
        .mask_wr_o  (mask_wr),
        .wval_o     (wval)
    );

    icm_cause_reg u_cause (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (cause_wr),
        .wval_i  (wval),
        .set_i   (cause_set_i),
        .cause_o (cause_q)
    );

    icm_mask_reg u_mask (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (mask_wr),
        .wval_i  (wval),
        .cause_i (cause_q),
        .mask_o  (mask_q),
        .trig_o  (mask_trig)
    );

    icm_irq_gen u_irq (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .mask_trig_i (mask_trig),
        .set_i       (cause_set_i),
        .mask_i      (mask_q),
        .irq_o       (irq_o)
    );

    always_comb begin
        unique case (sel)
            SEL_CAUSE: host_rdata_o = cause_q;
            SEL_MASK:  host_rdata_o = mask_q;
            default:   host_rdata_o = '0;
        endcase
    end

    // R11: writes elsewhere leave both registers alone
    p_unmapped_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (host_wr_i && sel == SEL_NONE && cause_set_i == '0)
            |=> ($stable(cause_q) && $stable(mask_q)));
endmodule

// File: tb/test_intr_cause_mask.sv
module test_intr_cause_mask;
    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic [2:0]  addr = '0;
    logic        wr = 1'b0;
    logic        wide = 1'b1;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [15:0] set_v = '0;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    logic pulse_seen;

    always #10 clk = ~clk;

    intr_cause_mask i_intr_cause_mask (
        .clk_i        (clk),
        .rst_ni       (rst_ni),
        .host_addr_i  (addr),
        .host_wr_i    (wr),
        .host_wide_i  (wide),
        .host_wdata_i (wdata),
        .host_rdata_o (rdata),
        .cause_set_i  (set_v),
        .irq_o        (irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one write cycle, optionally with set bits; capture irq one cycle later
    task automatic do_write(input logic [2:0] a, input logic w, input logic [15:0] d,
                            input logic [15:0] s);
        @(negedge clk);
        addr = a; wide = w; wdata = d; wr = 1'b1; set_v = s;
        @(negedge clk);
        wr = 1'b0; set_v = '0;
        pulse_seen = irq;
    endtask

    task automatic rd(input logic [2:0] a, input logic w, output logic [15:0] v);
        @(negedge clk);
        addr = a; wide = w;
        #1 v = rdata;
    endtask

    task automatic t_reset;
        logic [15:0] v;
        check("R1 irq", {15'b0, irq}, 16'h0);
        rd(3'd0, 1'b1, v); check("R1 cause", v, 16'h0);
        rd(3'd1, 1'b1, v); check("R1 mask", v, 16'h0);
    endtask

    task automatic t_cause_write;
        logic [15:0] v;
        do_write(3'd0, 1'b1, 16'hA5C3, '0);
        check("R10 no pulse on cause write", {15'b0, pulse_seen}, 16'h0);
        rd(3'd0, 1'b1, v); check("R3 cause wide", v, 16'hA5C3);
        do_write(3'd0, 1'b0, 16'h7E5A, '0);
        rd(3'd0, 1'b1, v); check("R3 cause narrow", v, 16'h005A);
    endtask

    task automatic t_read_width;
        logic [15:0] v;
        do_write(3'd0, 1'b1, 16'hBEEF, '0);
        rd(3'd0, 1'b0, v); check("R2 narrow read cause", v, 16'hBEEF);
        do_write(3'd1, 1'b1, 16'h0000, '0);
        rd(3'd5, 1'b1, v); check("R2 unmapped read", v, 16'h0000);
        do_write(3'd0, 1'b1, 16'h0000, '0);
    endtask

    task automatic t_set_priority;
        logic [15:0] v;
        do_write(3'd0, 1'b1, 16'h0000, 16'h0001);
        rd(3'd0, 1'b1, v); check("R4 set beats clear", v, 16'h0001);
        do_write(3'd0, 1'b1, 16'hF0F0, 16'h000F);
        rd(3'd0, 1'b1, v); check("R4 set merges with write", v, 16'hF0FF);
        do_write(3'd0, 1'b1, 16'h0000, '0);
    endtask

    task automatic t_mask_writes;
        logic [15:0] v;
        do_write(3'd1, 1'b1, 16'hABCD, '0);
        rd(3'd1, 1'b1, v); check("R5 mask wide", v, 16'hABCD);
        rd(3'd1, 1'b0, v); check("R2 narrow read mask", v, 16'hABCD);
        do_write(3'd1, 1'b0, 16'h12EF, '0);
        rd(3'd1, 1'b1, v); check("R6 mask narrow zero-extend", v, 16'h00EF);
        do_write(3'd1, 1'b1, 16'h0000, '0);
    endtask

    task automatic t_mask_pulse;
        do_write(3'd0, 1'b1, 16'h0010, '0);
        do_write(3'd1, 1'b1, 16'h0010, '0);
        check("R7 unmask pending pulses", {15'b0, pulse_seen}, 16'h1);
        @(negedge clk);
        check("R7 pulse lasts one cycle", {15'b0, irq}, 16'h0);
        do_write(3'd1, 1'b1, 16'h0010, '0);
        check("R8 same mask no pulse", {15'b0, pulse_seen}, 16'h0);
        do_write(3'd1, 1'b1, 16'h0000, '0);
        check("R7 masking pending pulses", {15'b0, pulse_seen}, 16'h1);
        do_write(3'd1, 1'b1, 16'h0100, '0);
        check("R9 disjoint change no pulse", {15'b0, pulse_seen}, 16'h0);
        do_write(3'd0, 1'b1, 16'h0000, '0);
    endtask

    task automatic t_set_pulse;
        logic [15:0] v;
        do_write(3'd1, 1'b1, 16'h0004, '0);
        @(negedge clk); set_v = 16'h0004;
        @(negedge clk); set_v = '0;
        check("R10 enabled set pulses", {15'b0, irq}, 16'h1);
        @(negedge clk);
        check("R10 pulse one cycle", {15'b0, irq}, 16'h0);
        set_v = 16'h0008;
        @(negedge clk); set_v = '0;
        check("R10 disabled set silent", {15'b0, irq}, 16'h0);
        rd(3'd0, 1'b1, v); check("R4 set bits recorded", v, 16'h000C);
    endtask

    task automatic t_unmapped;
        logic [15:0] v;
        do_write(3'd2, 1'b1, 16'hFFFF, '0);
        check("R11 no pulse", {15'b0, pulse_seen}, 16'h0);
        rd(3'd0, 1'b1, v); check("R11 cause kept", v, 16'h000C);
        rd(3'd1, 1'b1, v); check("R11 mask kept", v, 16'h0004);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_ni = 1'b1;
        t_reset();
        t_cause_write();
        t_read_width();
        t_set_priority();
        t_mask_writes();
        t_mask_pulse();
        t_set_pulse();
        t_unmapped();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule